// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block sends bytes over a clocked synchronous serial link. Software writes a byte into a holding register, which also clears the holding-empty flag. When the shifter is free, the block copies the held byte into its shift register and sets the empty flag again, so the next byte can be written while the current one is still leaving. Bits go out least significant first, one per serial clock period. The data line changes after a falling clock edge, so a receiver can sample it on the rising edge.

The serial clock comes from one of two sources. It can be generated inside the block from the system clock, with a half-period set by a parameter. It can also come from an external pin, in which case it passes through a two-flop synchronizer and its edges are detected in the system clock domain. While the most significant bit is being presented, the block looks at the empty flag. If a new byte is waiting when the frame ends, the next frame follows with no idle gap. If no byte is waiting, the block raises the end flag, finishes the last bit, parks the generated clock high and holds the data line at its last level. Each flag drives a level interrupt request that is gated by its own enable input.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, the empty flag `tdre` is 1, the end flag `tend` is 1, and both `sck_out` and `sdo` are 1.
- R2: A write (`wr_en` high for one cycle) stores `wr_data`, clears `tdre` and `tend` on the next edge, and when the shifter is idle the byte is moved to the shift register one cycle later, which sets `tdre` back to 1.
- R3: `txi_req` is 1 exactly when `tdre` and `tie` are both 1, and `tei_req` is 1 exactly when `tend` and `teie` are both 1.
- R4: A frame is 8 bits sent bit 0 first. `sdo` changes only in the cycle after a falling serial clock edge, and the value present at each rising edge is the current bit.
- R5: In internal clock mode (`ext_sel` = 0), each frame has exactly 8 clock pulses, and each clock phase lasts `HALF_DIV` system cycles. For a single frame, the first falling edge and the eighth rising edge are 15·`HALF_DIV` cycles apart.
- R6: A byte written before the most significant bit of the current frame is presented is sent in the next frame with no gap. For two such frames, the first falling edge and the last rising edge are 31·`HALF_DIV` cycles apart.
- R7: `tend` is set when the most significant bit is presented while `tdre` is 1. `tend` stays 0 at the end of a frame that is followed by a chained frame.
- R8: After the last frame, `sck_out` stays 1 and `sdo` keeps the value of the last bit sent, even if more external clock edges arrive.
- R9: In external clock mode (`ext_sel` = 1), bits advance on falling edges of `sck_in`, and `sck_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| ext_sel | input | 1 | 1 selects the external serial clock, 0 the internal generator |
| tie | input | 1 | Enable for the holding-empty interrupt |
| teie | input | 1 | Enable for the transmit-end interrupt |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock, high when idle |
| sdo | output | 1 | Serial data output |
| tdre | output | 1 | Holding register empty flag |
| tend | output | 1 | Transmission ended flag |
| txi_req | output | 1 | Holding-empty interrupt request |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
Single isolated bytes with alternating bit patterns show that the bit order is correct and that the frame length, measured in clock phases, matches the divider. A second byte written straight after the first load separates gap-free chaining from stop-and-restart: both timing and the value of `tend` at the frame boundary differ between the two. Random bytes, with a random choice between chaining and idling and random interrupt enables, cover the mix of transitions between the two cases. A hand-clocked external-clock frame, followed by extra stray clock pulses, checks that bits track the external falling edges and that the line holds its value once the frame is over.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } sst_edge_t;

  // Count of presented bits equals the index of the last bit.
  function automatic logic sst_is_msb(input int unsigned n, input int unsigned bits);
    return n == bits - 1;
  endfunction

  // All bits of the frame presented.
  function automatic logic sst_all_out(input int unsigned n, input int unsigned bits);
    return n == bits;
  endfunction

  // System cycles from first falling edge to final rising edge of a burst.
  function automatic int unsigned sst_span(input int unsigned half, input int unsigned bits,
                                           input int unsigned frames);
    return (2 * bits * frames - 1) * half;
  endfunction

endpackage

// File: rtl/sst_int_clk.sv
module sst_int_clk
  import sst_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  output logic      sck,
  output sst_edge_t ev
);
  localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = run && (cnt == LAST);
  assign ev.fall = wrap && sck;
  assign ev.rise = wrap && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sst_ext_sync.sv
module sst_ext_sync
  import sst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_in,
  output sst_edge_t ev
);
  logic [2:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= 3'b111;
    else        pipe <= {pipe[1:0], sck_in};
  end

  assign ev.rise = pipe[1] && !pipe[2];
  assign ev.fall = !pipe[1] && pipe[2];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  sst_edge_t         ev,
  output logic              sdo,
  output logic              tdre,
  output logic              tend,
  output logic              busy,
  output logic              load_ev,
  output logic              msb_fall_ev
);
  localparam int unsigned CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] nxt_data;
  logic [CW-1:0]     fcnt;
  logic              start_ev, end_ev, chain_ev, fall_act;

  assign nxt_data    = wr_en ? wr_data : hold_q;
  assign start_ev    = !busy && !tdre;
  assign end_ev      = busy && ev.rise && sst_all_out(fcnt, DATA_W);
  assign chain_ev    = end_ev && !tdre;
  assign load_ev     = start_ev || chain_ev;
  assign fall_act    = busy && ev.fall && (fcnt < CW'(DATA_W));
  assign msb_fall_ev = fall_act && sst_is_msb(fcnt, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      fcnt   <= '0;
      busy   <= 1'b0;
      tdre   <= 1'b1;
      tend   <= 1'b1;
      sdo    <= 1'b1;
    end else begin
      if (wr_en) hold_q <= wr_data;

      if (load_ev)    tdre <= 1'b1;
      else if (wr_en) tdre <= 1'b0;

      if (wr_en)                    tend <= 1'b0;
      else if (msb_fall_ev && tdre) tend <= 1'b1;

      if (load_ev)       sh_q <= nxt_data;
      else if (fall_act) sh_q <= sh_q >> 1;

      if (fall_act) sdo <= sh_q[0];

      if (load_ev || end_ev) fcnt <= '0;
      else if (fall_act)     fcnt <= fcnt + 1'b1;

      if (load_ev)     busy <= 1'b1;
      else if (end_ev) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_sel,
  input  logic              tie,
  input  logic              teie,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sdo,
  output logic              tdre,
  output logic              tend,
  output logic              txi_req,
  output logic              tei_req
);
  sst_edge_t int_ev, ext_ev, ev;
  logic      busy, load_ev, msb_fall_ev, fall_ev, gen_run;

  assign gen_run = busy && !ext_sel;
  assign ev      = ext_sel ? ext_ev : int_ev;
  assign fall_ev = ev.fall;

  sst_int_clk #(.HALF_DIV(HALF_DIV)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(gen_run), .sck(sck_out), .ev(int_ev)
  );

  sst_ext_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ev(ext_ev)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ev(ev),
    .sdo(sdo), .tdre(tdre), .tend(tend), .busy(busy),
    .load_ev(load_ev), .msb_fall_ev(msb_fall_ev)
  );

  assign txi_req = tdre && tie;
  assign tei_req = tend && teie;
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic ext_sel,
  input logic sck_out,
  input logic sdo,
  input logic tdre,
  input logic tend,
  input logic busy,
  input logic load_ev,
  input logic fall_ev,
  input logic msb_fall_ev
);
  p_load_sets_tdre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> tdre);

  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_ev) |=> (!tdre && !tend));

  p_sdo_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(fall_ev));

  p_tend_at_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> $past(msb_fall_ev));

  p_idle_clk_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  p_ext_no_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> sck_out);
endmodule

bind sync_ser_tx sst_checker chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ext_sel(ext_sel),
  .sck_out(sck_out), .sdo(sdo), .tdre(tdre), .tend(tend), .busy(busy),
  .load_ev(load_ev), .fall_ev(fall_ev), .msb_fall_ev(msb_fall_ev)
);

// File: tb/sync_ser_tx_tb_top.sv
module sync_ser_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int HD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ext_sel = 1'b0, tie = 1'b0, teie = 1'b0, sck_in = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic sck_out, sdo, tdre, tend, txi_req, tei_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ser_tx #(.DATA_W(DW), .HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ext_sel(ext_sel),
    .tie(tie), .teie(teie), .sck_in(sck_in), .sck_out(sck_out), .sdo(sdo),
    .tdre(tdre), .tend(tend), .txi_req(txi_req), .tei_req(tei_req)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int frame_span(input int frames);
    int t = 0;
    for (int e = 1; e < 2 * DW * frames; e++) t += HD;
    return t;
  endfunction

  // Receiver model on the generated clock
  int cyc = 0, first_fall = -1, last_rise = 0, rx_bits = 0, rx_cnt = 0;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] rx_q [0:63];
  logic tend_end [0:63];
  logic sck_q = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !ext_sel) begin
      if (sck_out && !sck_q) begin
        rx_sh = {sdo, rx_sh[DW-1:1]};
        rx_bits++;
        last_rise = cyc;
        if (rx_bits == DW) begin
          rx_q[rx_cnt] = rx_sh;
          tend_end[rx_cnt] = tend;
          rx_cnt++;
          rx_bits = 0;
        end
      end
      if (!sck_out && sck_q && first_fall < 0) first_fall = cyc;
    end
    sck_q = sck_out;
  end

  task automatic write_byte(input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] tx_q [0:63];
    int tx_cnt;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tdre", tdre, 1); chk("R1 tend", tend, 1);
    chk("R1 sck_out", sck_out, 1); chk("R1 sdo", sdo, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3 write clears flags, load sets tdre again
    tie = 1'b1; teie = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk); wr_en = 1'b0;
    chk("R2 tdre cleared", tdre, 0); chk("R2 tend cleared", tend, 0);
    chk("R3 txi low", txi_req, 0); chk("R3 tei low", tei_req, 0);
    @(negedge clk);
    chk("R2 tdre after load", tdre, 1); chk("R3 txi high", txi_req, 1);

    // R4/R5/R7/R8 single frame
    wait_rx(1);
    chk("R4 byte A5", rx_q[0], 8'hA5);
    chk("R5 single frame span", last_rise - first_fall, frame_span(1));
    chk("R7 tend at end", tend_end[0], 1);
    chk("R3 tei high", tei_req, 1);
    repeat (3 * HD) @(negedge clk);
    chk("R8 sck parked", sck_out, 1); chk("R8 sdo holds msb", sdo, 1);

    // R6/R7 chained frames
    first_fall = -1;
    write_byte(8'h3C);
    while (!tdre) @(negedge clk);
    write_byte(8'hC3);
    wait_rx(3);
    chk("R4 byte 3C", rx_q[1], 8'h3C);
    chk("R4 byte C3", rx_q[2], 8'hC3);
    chk("R6 chained span", last_rise - first_fall, frame_span(2));
    chk("R7 no tend when chained", tend_end[1], 0);
    chk("R7 tend after last", tend_end[2], 1);
    repeat (3 * HD) @(negedge clk);
    chk("R8 sdo holds msb of C3", sdo, 1);

    // Random bytes, random chaining and enables
    tx_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      logic [DW-1:0] d;
      d = DW'($urandom);
      tie = 1'($urandom); teie = 1'($urandom);
      while (!tdre) @(negedge clk);
      if ($urandom % 2 == 0) wait_rx(3 + tx_cnt);
      write_byte(d);
      tx_q[tx_cnt] = d; tx_cnt++;
      chk("R3 txi gating", txi_req, int'(tdre && tie));
      chk("R3 tei gating", tei_req, int'(tend && teie));
    end
    wait_rx(3 + tx_cnt);
    for (int i = 0; i < tx_cnt; i++) chk("R4 random byte", rx_q[3 + i], tx_q[i]);
    chk("R7 tend after random burst", tend, 1);

    // R9 external clock mode, hand-clocked
    repeat (4) @(negedge clk);
    ext_sel = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(8'h96);
    repeat (4) @(negedge clk);
    for (int b = 0; b < DW; b++) begin
      sck_in = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 ext bit", sdo, int'((8'h96 >> b) & 1));
      chk("R9 sck_out held", sck_out, 1);
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk("R7 ext tend", tend, 1);
    for (int k = 0; k < 2; k++) begin
      sck_in = 1'b0; repeat (6) @(negedge clk);
      sck_in = 1'b1; repeat (6) @(negedge clk);
    end
    chk("R8 ext sdo holds", sdo, 1);
    chk("R8 ext tdre stays", tdre, 1);

    finish_run();
  end
endmodule